// File: doc/BRIEF.md
# Fractional Sample-Rate Tick Generator

This block derives an audio sample-rate tick from one of three master rate sources. Each source reaches the block as a one-cycle enable strobe on the shared system clock. Source 0 runs at a 48.0 kHz base, source 1 at a 44.1 kHz base, and source 2 carries the clock recovered by the digital-audio receiver. On every strobe of the selected source, a Bresenham-style accumulator adds a programmed increment. When the sum reaches the programmed modulus, the block subtracts the modulus and emits one tick. The long-run output rate is therefore the source rate times increment/modulus, with no integer divide-by-N counter.

Software programs two registers. The first is a 2-bit source select. The second is a 32-bit ratio word: the increment sits in the low half, and the modulus sits in the high half, stored as modulus minus one. Writing either register restarts the accumulator from zero. A chip may carry several of these blocks, and a data port picks one of them by a small clock id. The block also drives a one-hot report of the source it is currently following.

Top module: `fracSampleClk`

## Requirements
- R1: After reset the select holds 0, so activeSrc reads 3'b001. The increment and the encoded modulus hold 0, and sampleTick stays low even while source 0 strobes.
- R2: Select code 0, 1 or 2 makes srcStb bit 0, 1 or 2 the counted strobe. From the cycle after the select write, activeSrc is the one-hot bit of that code.
- R3: Select code 3 is reserved. activeSrc then reads 3'b000, and no strobe produces a tick.
- R4: The increment is taken from ratioWrData[15:0]. The encoded modulus is taken from ratioWrData[31:16], and the modulus in use is that field plus one (1 to 65536).
- R5: Each counted strobe adds the increment to the accumulator. When the sum is at least the modulus, the modulus is subtracted and sampleTick is high for exactly the one cycle after the strobe cycle. Starting from a cleared accumulator with increment ≤ modulus, N strobes give floor(N·increment/modulus) ticks.
- R6: Strobes on unselected srcStb bits are ignored and produce no tick.
- R7: A write to either register clears the accumulator. A strobe in the same cycle as a write is discarded, so no tick follows it.
- R8: An increment of zero produces no ticks.
- R9: An increment larger than the modulus gives exactly one tick per counted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcStb | input | 3 | Master rate strobes: bit 0 is the 48.0 kHz base, bit 1 is the 44.1 kHz base, bit 2 is the recovered receiver clock |
| selWrEn | input | 1 | Write strobe for the source select register |
| selWrData | input | 2 | New source select code |
| ratioWrEn | input | 1 | Write strobe for the ratio register |
| ratioWrData | input | 32 | Ratio word: [15:0] increment, [31:16] modulus minus one |
| sampleTick | output | 1 | One-cycle sample-rate tick |
| activeSrc | output | 3 | One-hot indication of the followed source; zero when the reserved code is selected |

## Verification
A corrupt accumulator does not change the tick pulse itself; it shows up as a wrong tick count or as ticks in the wrong phase. So the bench counts ticks over a whole burst of strobes and compares the count with the floor of strobes times ratio. It also checks the first ticks right after a clear, where a residue that should have been wiped would move a tick earlier within one or two strobes. Two faults show up on the very next strobe: a swapped increment/modulus field and a wrong select decode. The first gives a visibly different count, and the second gives ticks from the wrong strobe bit or none at all.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  // Strobes from the control side to the accumulator datapath
  typedef struct packed {
    logic clearAcc;  // restart ratio from a zero residue
    logic stepEn;    // one counted strobe of the selected source
  } fscCtrl_t;

endpackage

// File: rtl/fscControl.sv
module fscControl
  import fsc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2,
  parameter int ACC_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcStb,
  input  logic               selWrEn,
  input  logic [SEL_W-1:0]   selWrData,
  input  logic               ratioWrEn,
  input  logic [2*ACC_W-1:0] ratioWrData,
  output fscCtrl_t           ctrl,
  output logic [ACC_W-1:0]   incVal,
  output logic [ACC_W:0]     modVal,
  output logic [NUM_SRC-1:0] activeSrc
);

  logic [SEL_W-1:0] selReg;
  logic [ACC_W-1:0] incReg;
  logic [ACC_W-1:0] modEncReg;
  logic [NUM_SRC-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg    <= '0;
      incReg    <= '0;
      modEncReg <= '0;
    end else begin
      if (selWrEn) selReg <= selWrData;
      if (ratioWrEn) begin
        incReg    <= ratioWrData[ACC_W-1:0];
        modEncReg <= ratioWrData[2*ACC_W-1:ACC_W];
      end
    end
  end

  // Decode the select into a one-hot source mask; unused codes decode to zero
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign activeSrc[i] = (selReg == SEL_W'(i));
    assign hitVec[i]    = activeSrc[i] & srcStb[i];
  end

  always_comb begin
    ctrl.clearAcc = selWrEn | ratioWrEn;
    ctrl.stepEn   = (|hitVec) & ~(selWrEn | ratioWrEn);
  end

  assign incVal = incReg;
  assign modVal = {1'b0, modEncReg} + {{ACC_W{1'b0}}, 1'b1};

endmodule

// File: rtl/fscDatapath.sv
module fscDatapath
  import fsc_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fscCtrl_t         ctrl,
  input  logic [ACC_W-1:0] incVal,
  input  logic [ACC_W:0]   modVal,
  output logic [ACC_W-1:0] accVal,
  output logic             tick
);

  localparam int SUM_W = ACC_W + 2;

  logic [ACC_W-1:0] accReg;
  logic [SUM_W-1:0] sumVal;
  logic [SUM_W-1:0] modExt;
  logic [SUM_W-1:0] diffVal;
  logic             wrapHit;
  logic             overShoot;
  logic [ACC_W-1:0] accNext;

  always_comb begin
    modExt    = {1'b0, modVal};
    sumVal    = {2'b00, accReg} + {2'b00, incVal};
    wrapHit   = sumVal >= modExt;
    diffVal   = sumVal - modExt;
    overShoot = diffVal >= modExt;
    if (!wrapHit)       accNext = sumVal[ACC_W-1:0];
    else if (overShoot) accNext = ACC_W'(modVal - 1'b1);  // saturate residue
    else                accNext = diffVal[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
      tick   <= 1'b0;
    end else if (ctrl.clearAcc) begin
      accReg <= '0;
      tick   <= 1'b0;
    end else if (ctrl.stepEn) begin
      accReg <= accNext;
      tick   <= wrapHit;
    end else begin
      tick   <= 1'b0;
    end
  end

  assign accVal = accReg;

endmodule

// File: rtl/fracSampleClk.sv
module fracSampleClk
  import fsc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2,
  parameter int ACC_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcStb,
  input  logic               selWrEn,
  input  logic [SEL_W-1:0]   selWrData,
  input  logic               ratioWrEn,
  input  logic [2*ACC_W-1:0] ratioWrData,
  output logic               sampleTick,
  output logic [NUM_SRC-1:0] activeSrc
);

  fscCtrl_t         ctrl;
  logic [ACC_W-1:0] incVal;
  logic [ACC_W:0]   modVal;
  logic [ACC_W-1:0] accVal;

  fscControl #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .ACC_W(ACC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcStb(srcStb),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .ratioWrEn(ratioWrEn), .ratioWrData(ratioWrData),
    .ctrl(ctrl), .incVal(incVal), .modVal(modVal), .activeSrc(activeSrc)
  );

  fscDatapath #(.ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .incVal(incVal), .modVal(modVal),
    .accVal(accVal), .tick(sampleTick)
  );

endmodule

// File: rtl/fracSampleClkChk.sv
module fracSampleClkChk #(
  parameter int NUM_SRC = 3,
  parameter int ACC_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcStb,
  input logic               selWrEn,
  input logic               ratioWrEn,
  input logic               sampleTick,
  input logic [NUM_SRC-1:0] activeSrc,
  input logic [ACC_W-1:0]   incVal,
  input logic [ACC_W:0]     modVal,
  input logic [ACC_W-1:0]   accVal
);

  AST_ACTIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(activeSrc)); // R2

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (activeSrc == '0) |=> !sampleTick); // R3

  AST_RESIDUE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, accVal} < modVal)); // R5

  AST_TICK_FROM_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> ($past(srcStb & activeSrc) != '0)); // R6

  AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (selWrEn || ratioWrEn) |=> !sampleTick); // R7

  AST_ZERO_INC_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (incVal == '0) |=> !sampleTick); // R8

  AST_BIG_INC_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    (((srcStb & activeSrc) != '0) && !selWrEn && !ratioWrEn &&
     ({1'b0, incVal} >= modVal)) |=> sampleTick); // R9

endmodule

bind fracSampleClk fracSampleClkChk #(.NUM_SRC(NUM_SRC), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcStb(srcStb), .selWrEn(selWrEn),
  .ratioWrEn(ratioWrEn), .sampleTick(sampleTick), .activeSrc(activeSrc),
  .incVal(incVal), .modVal(modVal), .accVal(accVal)
);

// File: tb/tb_fracSampleClk.sv
module tb_fracSampleClk;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] inc;
    logic [15:0] modEnc;
    logic [2:0]  mask;
    logic [7:0]  n;
    logic [7:0]  expTicks;
  } vec_t;

  // sel, increment, modulus-1, strobe mask, strobes, expected ticks
  localparam vec_t VECS [10] = '{
    '{2'd0, 16'd1,      16'd1,      3'b001, 8'd8,  8'd4},  // R5 half rate
    '{2'd1, 16'd2,      16'd4,      3'b010, 8'd10, 8'd4},  // R4 asymmetric fields
    '{2'd2, 16'd147,    16'd479,    3'b100, 8'd48, 8'd14}, // R5 fractional
    '{2'd0, 16'd5,      16'd1,      3'b001, 8'd6,  8'd6},  // R9 inc > modulus
    '{2'd1, 16'd0,      16'd9,      3'b010, 8'd10, 8'd0},  // R8 zero increment
    '{2'd3, 16'd1,      16'd0,      3'b111, 8'd6,  8'd0},  // R3 reserved select
    '{2'd0, 16'd1,      16'd0,      3'b110, 8'd6,  8'd0},  // R6 other sources
    '{2'd2, 16'd1,      16'd0,      3'b100, 8'd5,  8'd5},  // R2 source 2, ratio 1
    '{2'd0, 16'hFFFF,   16'hFFFF,   3'b001, 8'd3,  8'd2},  // R4 full-width modulus
    '{2'd1, 16'd3,      16'd3,      3'b011, 8'd8,  8'd6}   // R2 source 1 selected
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  srcStb = '0;
  logic        selWrEn = 1'b0;
  logic [1:0]  selWrData = '0;
  logic        ratioWrEn = 1'b0;
  logic [31:0] ratioWrData = '0;
  logic        sampleTick;
  logic [2:0]  activeSrc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fracSampleClk dut (
    .clk(clk), .rstN(rstN), .srcStb(srcStb), .selWrEn(selWrEn),
    .selWrData(selWrData), .ratioWrEn(ratioWrEn), .ratioWrData(ratioWrData),
    .sampleTick(sampleTick), .activeSrc(activeSrc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrSel(input logic [1:0] v);
    @(negedge clk); selWrEn = 1'b1; selWrData = v;
    @(negedge clk); selWrEn = 1'b0;
  endtask

  task automatic wrRatio(input logic [15:0] inc, input logic [15:0] modEnc);
    @(negedge clk); ratioWrEn = 1'b1; ratioWrData = {modEnc, inc};
    @(negedge clk); ratioWrEn = 1'b0;
  endtask

  // One strobe, then sample the tick slot and an idle slot; returns ticks seen
  task automatic pulse(input logic [2:0] mask, output int tickSeen, output int widthErr);
    @(negedge clk); srcStb = mask;
    @(negedge clk); srcStb = '0; tickSeen = int'(sampleTick);
    @(negedge clk); widthErr = int'(sampleTick);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t, w, total, wide;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 activeSrc", 32'(activeSrc), 32'b001);
    check("R1 tick", 32'(sampleTick), 0);
    total = 0;
    for (int k = 0; k < 4; k++) begin pulse(3'b001, t, w); total += t + w; end
    check("R1 no ticks after reset", 32'(total), 0);

    foreach (VECS[i]) begin
      wrSel(VECS[i].sel);
      wrRatio(VECS[i].inc, VECS[i].modEnc);
      check($sformatf("R2 activeSrc vec%0d", i), 32'(activeSrc),
            (VECS[i].sel == 2'd3) ? 32'd0 : (32'd1 << VECS[i].sel));
      total = 0; wide = 0;
      for (int k = 0; k < int'(VECS[i].n); k++) begin
        pulse(VECS[i].mask, t, w); total += t; wide += w;
      end
      check($sformatf("R5 tick count vec%0d", i), 32'(total), 32'(VECS[i].expTicks));
      check($sformatf("R5 single-cycle vec%0d", i), 32'(wide), 0);
    end

    // R7: ratio write wipes residue
    wrSel(2'd0); wrRatio(16'd1, 16'd1);
    pulse(3'b001, t, w); check("R7 first strobe", 32'(t), 0);
    wrRatio(16'd1, 16'd1);
    pulse(3'b001, t, w); check("R7 ratio write clears", 32'(t), 0);
    pulse(3'b001, t, w); check("R7 tick after clear", 32'(t), 1);

    // R7: select write wipes residue
    pulse(3'b001, t, w);
    wrSel(2'd0);
    pulse(3'b001, t, w); check("R7 select write clears", 32'(t), 0);

    // R7: strobe coincident with write is discarded
    wrRatio(16'd1, 16'd0);
    @(negedge clk); srcStb = 3'b001; ratioWrEn = 1'b1; ratioWrData = {16'd0, 16'd1};
    @(negedge clk); srcStb = '0; ratioWrEn = 1'b0;
    check("R7 coincident strobe dropped", 32'(sampleTick), 0);
    pulse(3'b001, t, w); check("R7 next strobe ticks", 32'(t), 1);

    // R1: reset returns to defaults
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; wrSel(2'd0); rstN = 1'b1;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 activeSrc after reset", 32'(activeSrc), 32'b001);
    pulse(3'b001, t, w); check("R1 silent after reset", 32'(t + w), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule